// File: doc/BRIEF.md
# Repeat-Read SSI Encoder Master

This block is the master side of a synchronous serial interface (SSI) link to an absolute position encoder. An external cycle trigger starts each read. The master drives the clock line and shifts in a word of `DATA_BITS` bits from the data line. It then publishes the word as the position value, together with an 8-bit status byte.

For an integrity check, a read can be made of two or three clock bursts. Each later burst starts a short gap after the previous one, which keeps it inside the encoder's monoflop window. The encoder therefore sends the same word again. The master compares every copy against the first one and flags any difference. The position published is the first copy whose frame ended correctly.

Each read also checks three line conditions: the idle level of the data line at the trigger, the level that ends each frame, and, when enabled, a power-failure flag carried in the last data bit. After the last burst the clock stays high for a monoflop wait before the next trigger is accepted. A trigger that arrives too early is dropped, and the next status byte reports it.

Top module: `ssi_repeat_master`

## Requirements
- R1: After reset, `ssi_clk` is high and `pub`, `status` and `pos_out` are all zero.
- R2: Within a burst, the clock low phase and the clock high phase each last `CLK_DIV` system cycles. Each burst has exactly `DATA_BITS`+1 falling edges. The first falling edge latches the encoder.
- R3: Data is sampled on rising edges 2 to `DATA_BITS`+1 of a burst, MSB first, and assembled into `pos_out`.
- R4: `cfg_bursts` is sampled at the trigger and sets the number of bursts per read: 1, 2 or 3. The value 0 acts as 1. Between two bursts the clock stays high for a high phase plus `GAP_CYCLES` cycles.
- R5: Status bit 3 is set when any later copy of the word differs from the first copy. With one burst, bit 3 is always 0.
- R6: `pos_out` takes the first copy whose frame check passed. If no copy passed, `pos_out` takes the first copy.
- R7: Each burst samples the data line one high phase after its last rising edge, and the line must be low at that point. If it is high in any burst, status bit 1 is set. Status bit 6 (invalid) is set when no copy passed this check.
- R8: When `cfg_pf_en` is 1 at the trigger, status bit 2 equals bit 0 of the published word. Otherwise status bit 2 is 0.
- R9: If `ssi_data` is low in the cycle the trigger is accepted, status bit 0 is set, and so is status bit 6.
- R10: `pub` is a one-cycle pulse. `status` and `pos_out` change only in that cycle, and status bit 7 inverts on every publication.
- R11: A trigger that arrives while a read or its monoflop wait is in progress starts no clock edges. It sets status bit 5 in the next publication, and the publication after that clears bit 5 again.
- R12: Status bit 4 always reads 0.
- R13: After the last burst of a read, the next falling edge of `ssi_clk` comes no earlier than `MONO_CYCLES` cycles after `pub`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Cycle trigger; starts a read when the master is idle |
| cfg_bursts | input | 2 | Bursts per read (0 or 1 = single, 2, 3) |
| cfg_pf_en | input | 1 | Treat the last data bit as the encoder's power-fail flag |
| ssi_clk | output | 1 | Clock line to the encoder; idles high |
| ssi_data | input | 1 | Data line from the encoder |
| pos_out | output | DATA_BITS | Published position word |
| status | output | 8 | Status byte: 7 toggle, 6 invalid, 5 sync error, 4 reserved, 3 mismatch, 2 power fail, 1 frame error, 0 data error |
| pub | output | 1 | One-cycle pulse when `pos_out` and `status` are updated |

## Verification
The bench runs a triple-burst read in which only the first copy has a bad frame end. A design that published the first copy, or that marked the whole read invalid, would show a wrong position or a set bit 6. Mismatching copies and a `cfg_bursts` value of zero are checked by counting falling edges. This exposes any design that adds or drops a burst, and any design that takes the zero literally. Triggers are sent both in the middle of a read and during the monoflop wait. Accepting either one shows up as extra clock edges, and the bench also checks that bit 5 is reported exactly once. The idle-low data line and the power-fail bit are checked with words whose LSB is set and with words whose LSB is clear.

// File: rtl/ssi_rm_pkg.sv
package ssi_rm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_GAP,
      ST_MONO
   } ssi_state_e;

   localparam int SB_DATA_ERR  = 0;
   localparam int SB_FRAME_ERR = 1;
   localparam int SB_PWR_FAIL  = 2;
   localparam int SB_RSVD      = 4;
   localparam int SB_MISMATCH  = 3;
   localparam int SB_SYNC_ERR  = 5;
   localparam int SB_INVALID   = 6;
   localparam int SB_TOGGLE    = 7;

   // a request of zero bursts is served as a single transmission
   function automatic logic [1:0] burst_count(input logic [1:0] raw);
      return (raw == 2'd0) ? 2'd1 : raw;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ssi_rm_timer.sv
module ssi_rm_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/ssi_rm_shift.sv
module ssi_rm_shift #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         din,
   output logic [N-1:0] word
);

   generate
      if (N == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  word <= '0;
            else if (en) word <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  word <= '0;
            else if (en) word <= {word[N-2:0], din};
         end
      end
   endgenerate

endmodule

// File: rtl/ssi_rm_copy_chk.sv
module ssi_rm_copy_chk #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         copy_done,
   input  logic         copy_first,
   input  logic         frame_ok,
   input  logic [N-1:0] word,
   output logic [N-1:0] ref_word,
   output logic [N-1:0] sel_word,
   output logic         mismatch,
   output logic         any_valid,
   output logic         any_frame_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_word      <= '0;
         sel_word      <= '0;
         mismatch      <= 1'b0;
         any_valid     <= 1'b0;
         any_frame_err <= 1'b0;
      end else if (start) begin
         mismatch      <= 1'b0;
         any_valid     <= 1'b0;
         any_frame_err <= 1'b0;
      end else if (copy_done) begin
         if (copy_first) begin
            ref_word <= word;
         end else if (word != ref_word) begin
            mismatch <= 1'b1;
         end
         if (!frame_ok) begin
            any_frame_err <= 1'b1;
         end
         if (frame_ok && !any_valid) begin
            sel_word  <= word;
            any_valid <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ssi_repeat_master.sv
module ssi_repeat_master
   import ssi_rm_pkg::*;
#(
   parameter int DATA_BITS   = 16,
   parameter int CLK_DIV     = 4,
   parameter int GAP_CYCLES  = 8,
   parameter int MONO_CYCLES = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trig,
   input  logic [1:0]           cfg_bursts,
   input  logic                 cfg_pf_en,
   output logic                 ssi_clk,
   input  logic                 ssi_data,
   output logic [DATA_BITS-1:0] pos_out,
   output logic [7:0]           status,
   output logic                 pub
);

   localparam int MAX_LOAD = max3(CLK_DIV, GAP_CYCLES, MONO_CYCLES);
   localparam int TW       = $clog2(MAX_LOAD + 1);
   localparam int EW       = $clog2(DATA_BITS + 2);
   localparam logic [EW-1:0] LAST_EDGE = EW'(DATA_BITS + 1);

   generate
      if (DATA_BITS < 1 || DATA_BITS > 32) begin : g_bad_bits
         $error("DATA_BITS must lie between 1 and 32");
      end
      if (CLK_DIV < 1 || GAP_CYCLES < 1 || MONO_CYCLES < 1) begin : g_bad_time
         $error("CLK_DIV, GAP_CYCLES and MONO_CYCLES must be at least 1");
      end
   endgenerate

   ssi_state_e     st, st_n;
   logic [EW-1:0]  edge_cnt;
   logic [1:0]     burst_idx, burst_tot;
   logic           pf_q, data_err, sync_pend, pub_pend, clk_q, pub_q;
   logic [7:0]     status_q;
   logic [DATA_BITS-1:0] pos_q;

   logic           tmr_load, tmr_exp;
   logic [TW-1:0]  tmr_val;
   logic           sh_en, copy_done, accept;
   logic [DATA_BITS-1:0] sh_word, ref_word, sel_word, pub_word;
   logic           mismatch, any_valid, any_frame_err;

   assign accept = (st == ST_IDLE) && trig;

   // ---------------- sequencing ----------------
   always_comb begin
      st_n = st;
      unique case (st)
         ST_IDLE: if (trig)    st_n = ST_LOW;
         ST_LOW:  if (tmr_exp) st_n = ST_HIGH;
         ST_HIGH: if (tmr_exp) begin
            if (edge_cnt != LAST_EDGE)            st_n = ST_LOW;
            else if ((burst_idx + 2'd1) < burst_tot) st_n = ST_GAP;
            else                                  st_n = ST_MONO;
         end
         ST_GAP:  if (tmr_exp) st_n = ST_LOW;
         ST_MONO: if (tmr_exp) st_n = ST_IDLE;
         default:              st_n = ST_IDLE;
      endcase
   end

   always_comb begin
      tmr_load = (st_n != st);
      unique case (st_n)
         ST_LOW, ST_HIGH: tmr_val = TW'(CLK_DIV - 1);
         ST_GAP:          tmr_val = TW'(GAP_CYCLES - 1);
         ST_MONO:         tmr_val = TW'(MONO_CYCLES - 1);
         default:         tmr_val = '0;
      endcase
   end

   ssi_rm_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   // rising edge leaves the low phase; the first one only completes the latch
   assign sh_en     = (st == ST_LOW) && tmr_exp && (edge_cnt != '0);
   assign copy_done = (st == ST_HIGH) && tmr_exp && (edge_cnt == LAST_EDGE);

   ssi_rm_shift #(.N(DATA_BITS)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sh_en),
      .din   (ssi_data),
      .word  (sh_word)
   );

   ssi_rm_copy_chk #(.N(DATA_BITS)) u_copy (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (accept),
      .copy_done     (copy_done),
      .copy_first    (burst_idx == 2'd0),
      .frame_ok      (!ssi_data),
      .word          (sh_word),
      .ref_word      (ref_word),
      .sel_word      (sel_word),
      .mismatch      (mismatch),
      .any_valid     (any_valid),
      .any_frame_err (any_frame_err)
   );

   assign pub_word = any_valid ? sel_word : ref_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         edge_cnt  <= '0;
         burst_idx <= '0;
         burst_tot <= 2'd1;
         pf_q      <= 1'b0;
         data_err  <= 1'b0;
         sync_pend <= 1'b0;
         pub_pend  <= 1'b0;
         clk_q     <= 1'b1;
         pub_q     <= 1'b0;
         status_q  <= '0;
         pos_q     <= '0;
      end else begin
         st    <= st_n;
         clk_q <= (st_n != ST_LOW);
         pub_q <= 1'b0;

         if (accept) begin
            burst_idx <= '0;
            edge_cnt  <= '0;
            burst_tot <= burst_count(cfg_bursts);
            pf_q      <= cfg_pf_en;
            data_err  <= !ssi_data;
         end else if (st == ST_LOW && tmr_exp) begin
            edge_cnt <= edge_cnt + 1'b1;
         end else if (st == ST_GAP && tmr_exp) begin
            edge_cnt  <= '0;
            burst_idx <= burst_idx + 2'd1;
         end

         // last copy lands in the checker on this edge; publish one cycle later
         pub_pend <= copy_done && (st_n == ST_MONO);

         if (pub_pend) begin
            pub_q                  <= 1'b1;
            pos_q                  <= pub_word;
            status_q[SB_TOGGLE]    <= ~status_q[SB_TOGGLE];
            status_q[SB_INVALID]   <= data_err | ~any_valid;
            status_q[SB_SYNC_ERR]  <= sync_pend;
            status_q[SB_RSVD]      <= 1'b0;
            status_q[SB_MISMATCH]  <= mismatch;
            status_q[SB_PWR_FAIL]  <= pf_q & pub_word[0];
            status_q[SB_FRAME_ERR] <= any_frame_err;
            status_q[SB_DATA_ERR]  <= data_err;
         end

         if (trig && st != ST_IDLE) sync_pend <= 1'b1;
         else if (pub_pend)          sync_pend <= 1'b0;
      end
   end

   assign ssi_clk = clk_q;
   assign pos_out = pos_q;
   assign status  = status_q;
   assign pub     = pub_q;

endmodule

// File: rtl/ssi_repeat_master_chk.sv
module ssi_repeat_master_chk #(
   parameter int DATA_BITS   = 16,
   parameter int CLK_DIV     = 4,
   parameter int MONO_CYCLES = 40
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_pf_en,
   input logic                 ssi_clk,
   input logic [DATA_BITS-1:0] pos_out,
   input logic [7:0]           status,
   input logic                 pub
);

   int   low_len;
   int   since_pub;
   logic after_pub;
   logic clk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_len   <= 0;
         since_pub <= 0;
         after_pub <= 1'b0;
         clk_prev  <= 1'b1;
      end else begin
         clk_prev <= ssi_clk;
         low_len  <= ssi_clk ? 0 : low_len + 1;
         if (pub) begin
            since_pub <= 0;
            after_pub <= 1'b1;
         end else begin
            if (since_pub < MONO_CYCLES + 4) since_pub <= since_pub + 1;
            if (clk_prev && !ssi_clk) after_pub <= 1'b0;
         end
      end
   end

   AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ssi_clk) |-> (low_len == CLK_DIV));                          // R2

   AST_PUB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pub |=> !pub);                                                      // R10

   AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      pub |-> (status[7] != $past(status[7])));                           // R10

   AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !pub |-> ($stable(status) && $stable(pos_out)));                    // R10

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status[4] == 1'b0);                                                 // R12

   AST_PF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (pub && !cfg_pf_en) |-> !status[2]);                                // R8

   AST_DATA_ERR_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] |-> status[6]);                                           // R9

   // pub arrives one cycle into the wait, hence the minus one
   AST_MONO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ssi_clk) && after_pub) |-> (since_pub >= MONO_CYCLES - 1));  // R13

endmodule

bind ssi_repeat_master ssi_repeat_master_chk #(
   .DATA_BITS   (DATA_BITS),
   .CLK_DIV     (CLK_DIV),
   .MONO_CYCLES (MONO_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_pf_en (cfg_pf_en),
   .ssi_clk   (ssi_clk),
   .pos_out   (pos_out),
   .status    (status),
   .pub       (pub)
);

// File: tb/tb_ssi_repeat_master.sv
`timescale 1ns/1ps
module tb_ssi_repeat_master;

   localparam int DB   = 16;
   localparam int CD   = 4;
   localparam int GAP  = 8;
   localparam int MONO = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic [1:0]    cfg_bursts = 2'd1;
   logic          cfg_pf_en = 1'b0;
   logic          ssi_clk;
   logic          sd = 1'b1;
   logic [DB-1:0] pos_out;
   logic [7:0]    status;
   logic          pub;

   int checks = 0;
   int errors = 0;
   logic exp_tog = 1'b0;

   always #2.5 clk = ~clk;

   ssi_repeat_master #(
      .DATA_BITS(DB), .CLK_DIV(CD), .GAP_CYCLES(GAP), .MONO_CYCLES(MONO)
   ) dut (
      .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_bursts(cfg_bursts),
      .cfg_pf_en(cfg_pf_en), .ssi_clk(ssi_clk), .ssi_data(sd),
      .pos_out(pos_out), .status(status), .pub(pub)
   );

   // encoder model: one word and one frame-end level per burst
   logic [DB-1:0] ew [0:2];
   logic          eb [0:2];
   int fk = 0, rk = 0, bi = 0, falls = 0;

   always @(negedge ssi_clk) begin
      falls = falls + 1;
      fk = fk + 1;
      #1;
      if (fk == 1) sd = 1'b0;
      else         sd = ew[bi][DB-fk+1];
   end

   always @(posedge ssi_clk) begin
      if (fk != 0) begin
         rk = rk + 1;
         if (rk == DB + 1) begin
            #1;
            sd = eb[bi];
            if (bi < 2) bi = bi + 1;
            fk = 0;
            rk = 0;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] sbyte(input logic tog, input logic inv, input logic syn,
                                        input logic mis, input logic pf, input logic fe,
                                        input logic de);
      return {tog, inv, syn, 1'b0, mis, pf, fe, de};
   endfunction

   logic [7:0]    r_sb;
   logic [DB-1:0] r_pos;
   int            r_falls;

   task automatic run_read(input logic [1:0] nb, input logic pf, input logic idle_lvl,
                           input logic [DB-1:0] w0, input logic [DB-1:0] w1,
                           input logic [DB-1:0] w2, input logic b0, input logic b1,
                           input logic b2, input int mid_at, input logic trig_mono);
      logic got;
      @(negedge clk);
      cfg_bursts = nb; cfg_pf_en = pf; sd = idle_lvl;
      ew[0] = w0; ew[1] = w1; ew[2] = w2;
      eb[0] = b0; eb[1] = b1; eb[2] = b2;
      fk = 0; rk = 0; bi = 0; falls = 0;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      got = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         trig = (i == mid_at);
         if (pub) begin
            got = 1'b1; r_sb = status; r_pos = pos_out;
            break;
         end
         @(negedge clk);
      end
      trig = trig_mono;
      @(negedge clk);
      trig = 1'b0;
      if (got) exp_tog = ~exp_tog;
      chk("R10", "publication seen", {31'd0, got}, 32'd1);
      repeat (MONO + 6) @(negedge clk);
      r_falls = falls;
      sd = 1'b1;
   endtask

   task automatic t_reset;
      chk("R1", "ssi_clk idle", {31'd0, ssi_clk}, 32'd1);
      chk("R1", "pub", {31'd0, pub}, 32'd0);
      chk("R1", "status", {24'd0, status}, 32'd0);
      chk("R1", "pos_out", {16'd0, pos_out}, 32'd0);
   endtask

   task automatic t_single;
      run_read(2'd1, 1'b0, 1'b1, 16'hA5C3, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R3", "position MSB first", {16'd0, r_pos}, 32'h0000A5C3);
      chk("R2", "falling edges single", r_falls, DB + 1);
      chk("R12", "status single", {24'd0, r_sb}, {24'd0, sbyte(exp_tog, 0, 0, 0, 0, 0, 0)});
      run_read(2'd1, 1'b0, 1'b1, 16'h3C01, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R3", "second pattern", {16'd0, r_pos}, 32'h00003C01);
      chk("R10", "toggle inverted", {31'd0, r_sb[7]}, {31'd0, exp_tog});
   endtask

   task automatic t_pf;
      run_read(2'd1, 1'b1, 1'b1, 16'h1235, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R8", "pf lsb one", {24'd0, r_sb}, {24'd0, sbyte(exp_tog, 0, 0, 0, 1, 0, 0)});
      run_read(2'd1, 1'b1, 1'b1, 16'h8000, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R8", "pf lsb zero", {31'd0, r_sb[2]}, 32'd0);
      run_read(2'd1, 1'b0, 1'b1, 16'h0001, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R8", "pf disabled", {31'd0, r_sb[2]}, 32'd0);
   endtask

   task automatic t_multi;
      run_read(2'd3, 1'b0, 1'b1, 16'h7E81, 16'h7E81, 16'h7E81, 0, 0, 0, -1, 1'b0);
      chk("R4", "falling edges triple", r_falls, 3 * (DB + 1));
      chk("R5", "status triple match", {24'd0, r_sb}, {24'd0, sbyte(exp_tog, 0, 0, 0, 0, 0, 0)});
      chk("R3", "triple position", {16'd0, r_pos}, 32'h00007E81);
      run_read(2'd2, 1'b0, 1'b1, 16'h4444, 16'h4445, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R4", "falling edges double", r_falls, 2 * (DB + 1));
      chk("R5", "mismatch flagged", {24'd0, r_sb}, {24'd0, sbyte(exp_tog, 0, 0, 1, 0, 0, 0)});
      chk("R6", "first copy kept", {16'd0, r_pos}, 32'h00004444);
      run_read(2'd0, 1'b0, 1'b1, 16'hBEEF, 16'h1111, 16'h2222, 0, 0, 0, -1, 1'b0);
      chk("R4", "zero acts as one", r_falls, DB + 1);
      chk("R5", "single never mismatches", {31'd0, r_sb[3]}, 32'd0);
   endtask

   task automatic t_frame;
      run_read(2'd1, 1'b0, 1'b1, 16'h0F0F, 16'h0, 16'h0, 1, 0, 0, -1, 1'b0);
      chk("R7", "single frame error", {24'd0, r_sb}, {24'd0, sbyte(exp_tog, 1, 0, 0, 0, 1, 0)});
      chk("R6", "no valid copy gives first", {16'd0, r_pos}, 32'h00000F0F);
      run_read(2'd3, 1'b0, 1'b1, 16'h1357, 16'h2468, 16'h2468, 1, 0, 0, -1, 1'b0);
      chk("R6", "first valid copy", {16'd0, r_pos}, 32'h00002468);
      chk("R7", "frame err but valid", {24'd0, r_sb}, {24'd0, sbyte(exp_tog, 0, 0, 1, 0, 1, 0)});
   endtask

   task automatic t_data_err;
      run_read(2'd1, 1'b0, 1'b0, 16'h6006, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R9", "idle low", {24'd0, r_sb}, {24'd0, sbyte(exp_tog, 1, 0, 0, 0, 0, 1)});
      run_read(2'd1, 1'b0, 1'b1, 16'h6006, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R9", "idle high clears", {31'd0, r_sb[0]}, 32'd0);
   endtask

   task automatic t_sync;
      run_read(2'd1, 1'b0, 1'b1, 16'hC0DE, 16'h0, 16'h0, 0, 0, 0, 40, 1'b0);
      chk("R11", "mid-read trigger ignored", r_falls, DB + 1);
      chk("R11", "sync bit set", {24'd0, r_sb}, {24'd0, sbyte(exp_tog, 0, 1, 0, 0, 0, 0)});
      run_read(2'd1, 1'b0, 1'b1, 16'hC0DE, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R11", "sync bit cleared", {31'd0, r_sb[5]}, 32'd0);
      run_read(2'd1, 1'b0, 1'b1, 16'hFACE, 16'h0, 16'h0, 0, 0, 0, -1, 1'b1);
      chk("R13", "trigger in monoflop wait ignored", r_falls, DB + 1);
      run_read(2'd1, 1'b0, 1'b1, 16'hFACE, 16'h0, 16'h0, 0, 0, 0, -1, 1'b0);
      chk("R11", "sync from wait trigger", {31'd0, r_sb[5]}, 32'd1);
   endtask

   initial begin
      ew[0] = '0; ew[1] = '0; ew[2] = '0;
      eb[0] = 1'b0; eb[1] = 1'b0; eb[2] = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_single;
      t_pf;
      t_multi;
      t_frame;
      t_data_err;
      t_sync;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule